// File: doc/BRIEF.md
# BCD Calendar Counter with Test Output

This block keeps wall-clock time and calendar date in packed BCD. A prescaler counts the cycles on which the oscillator-rate enable `osc_en` is high. Every `TICK_DIV` such cycles it produces one internal one-second tick. With the default of 32768, a 32768 Hz enable gives one tick per second.

On each tick the seconds field advances. A carry ripples through minutes, hours (24-hour format), date, month and two-digit year within the same tick. The day-of-week field advances whenever the date does. Month lengths and February in leap years are corrected automatically.

A register bank above the block can write all seven fields at once through a parallel load strobe, and it reads the live values on the output ports. An oscillator stop input freezes the prescaler and the calendar. A frequency-test input replaces the seconds LSB on the output with a square wave taken from the prescaler. With the default parameters that wave runs at 512 Hz.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the outputs read 00:00:00 for hours, minutes and seconds, 01 for day of week, 01 for date, 01 for month and 00 for year, and the prescaler is zero.
- R2: Seconds advance by one in BCD exactly on the `TICK_DIV`-th clock cycle with `osc_en`=1 and `osc_stop`=0. Cycles with `osc_en`=0 change nothing. Seconds 59 wrap to 00 and carry into minutes.
- R3: Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into date, all within the same tick.
- R4: Date wraps to 01 and carries into month after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and after 28 in February of a non-leap year.
- R5: A year whose BCD value is divisible by 4, 00 included, is a leap year, and in it February runs to date 29 before wrapping to 03-01.
- R6: Day of week advances by one whenever the date advances, and 07 wraps to 01.
- R7: Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00. 23:59:59 on 12-31 of year 99 becomes 00:00:00 on 01-01 of year 00 in one tick.
- R8: While `osc_stop`=1, `osc_en` pulses neither advance the prescaler nor change any field. On release, counting resumes from the held prescaler value.
- R9: A cycle with `load`=1 writes all seven fields from the `set_*` inputs at that clock edge and clears the prescaler, so the next tick needs a full `TICK_DIV` enabled cycles. A load takes priority over a tick due in the same cycle.
- R10: With `ftest`=1 and `osc_stop`=0, bit 0 of `sec_o` shows prescaler bit log2(`TEST_DIV`)-1. That bit toggles every `TEST_DIV`/2 enabled cycles, which is 512 Hz at the default parameters. Bits 7..1 are unchanged. Otherwise bit 0 is the true seconds LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate enable, one cycle per oscillator period |
| osc_stop | input | 1 | 1 halts prescaler and counting |
| ftest | input | 1 | 1 puts the test square wave on the seconds LSB |
| load | input | 1 | Parallel load strobe for all fields |
| set_sec | input | 8 | BCD seconds to load |
| set_min | input | 8 | BCD minutes to load |
| set_hour | input | 8 | BCD hours to load |
| set_wday | input | 8 | BCD day of week to load |
| set_date | input | 8 | BCD date to load |
| set_month | input | 8 | BCD month to load |
| set_year | input | 8 | BCD year to load |
| sec_o | output | 8 | Live seconds, LSB replaced in test mode |
| min_o | output | 8 | Live minutes |
| hour_o | output | 8 | Live hours |
| wday_o | output | 8 | Live day of week |
| date_o | output | 8 | Live date |
| month_o | output | 8 | Live month |
| year_o | output | 8 | Live year |

## Verification
A tick lands on the clock edge that consumes the `TICK_DIV`-th enabled cycle, and the whole carry chain is visible after that same edge. The bench drives `osc_en` for an exact number of cycles and samples on the falling edge that follows: once after one cycle less, to show nothing moved, and once after the final cycle. A load is visible one edge after the strobe. The test-mode LSB is combinational from the prescaler register and `ftest`, so it is checked a few nanoseconds after the inputs change. Stop and priority cases are checked by holding the expected value across the stimulus window and then confirming that the next tick arrives at the predicted count.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                 wday: 8'h01, hour: 8'h00, min: 8'h00,
                                 sec: 8'h00};

  // Add one to a two-digit packed BCD value (caller handles the top wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] lo;
    logic [3:0] hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo == 4'd9) return {hi + 4'd1, 4'd0};
    return {hi, lo + 4'd1};
  endfunction

  // BCD year divisible by four: (10*t + u) mod 4 == (2*t + u) mod 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] s;
    s = yr[1:0] + {yr[4], 1'b0};
    return (s == 2'b00);
  endfunction

  // Last valid date of a month, in BCD.
  function automatic logic [7:0] month_last(input logic [7:0] mon,
                                             input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Step a field by one, wrapping from its last value back to its first.
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                           input logic [7:0] last,
                                           input logic [7:0] first);
    return (v == last) ? first : bcd_inc(v);
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
  parameter int TICK_DIV = 32768,
  parameter int TEST_DIV = 64,
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
  localparam int TB = (TEST_DIV > 1) ? $clog2(TEST_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          halt,
  input  logic          clear,
  output logic          tick,
  output logic          test_bit,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
  localparam bit POW2 = ((TICK_DIV & (TICK_DIV - 1)) == 0);

  logic          adv;
  logic          at_last;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] cnt_nxt;

  assign adv      = osc_en & ~halt;
  assign at_last  = (cnt == LAST);
  assign tick     = adv & at_last & ~clear;
  assign test_bit = cnt[TB-1];

  generate
    if (POW2) begin : g_pow2
      // Natural binary wrap matches the divide ratio.
      assign cnt_inc = cnt + 1'b1;
    end else begin : g_any
      assign cnt_inc = at_last ? '0 : cnt + 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_nxt = cnt;
    if (clear)    cnt_nxt = '0;
    else if (adv) cnt_nxt = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/cal_counter.sv
`timescale 1ns/1ps
module cal_counter
  import cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cal_t load_val,
  input  logic tick,
  output cal_t cur,
  output logic date_adv,
  output logic year_adv
);

  logic sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;
  logic c_min, c_hour, c_month;
  logic [7:0] last_date;
  cal_t nxt;

  assign last_date  = month_last(cur.month, cur.year);
  assign sec_wrap   = (cur.sec == 8'h59);
  assign min_wrap   = (cur.min == 8'h59);
  assign hour_wrap  = (cur.hour == 8'h23);
  assign date_wrap  = (cur.date == last_date);
  assign month_wrap = (cur.month == 8'h12);

  // Carry chain: every stage settles within the same tick.
  assign c_min    = tick & sec_wrap;
  assign c_hour   = c_min & min_wrap;
  assign date_adv = c_hour & hour_wrap;
  assign c_month  = date_adv & date_wrap;
  assign year_adv = c_month & month_wrap;

  always_comb begin
    nxt = cur;
    if (load) begin
      nxt = load_val;
    end else begin
      if (tick)     nxt.sec   = bcd_step(cur.sec, 8'h59, 8'h00);
      if (c_min)    nxt.min   = bcd_step(cur.min, 8'h59, 8'h00);
      if (c_hour)   nxt.hour  = bcd_step(cur.hour, 8'h23, 8'h00);
      if (date_adv) begin
        nxt.date = bcd_step(cur.date, last_date, 8'h01);
        nxt.wday = bcd_step(cur.wday, 8'h07, 8'h01);
      end
      if (c_month)  nxt.month = bcd_step(cur.month, 8'h12, 8'h01);
      if (year_adv) nxt.year  = bcd_step(cur.year, 8'h99, 8'h00);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= CAL_RESET;
    else        cur <= nxt;
  end

endmodule

// File: rtl/cal_view.sv
`timescale 1ns/1ps
module cal_view
  import cal_pkg::*;
(
  input  logic       ftest,
  input  logic       halt,
  input  logic       test_bit,
  input  cal_t       cur,
  output logic [7:0] sec_v,
  output logic [7:0] min_v,
  output logic [7:0] hour_v,
  output logic [7:0] wday_v,
  output logic [7:0] date_v,
  output logic [7:0] month_v,
  output logic [7:0] year_v
);

  logic use_test;
  assign use_test = ftest & ~halt;

  assign sec_v   = {cur.sec[7:1], use_test ? test_bit : cur.sec[0]};
  assign min_v   = cur.min;
  assign hour_v  = cur.hour;
  assign wday_v  = cur.wday;
  assign date_v  = cur.date;
  assign month_v = cur.month;
  assign year_v  = cur.year;

endmodule

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32768,
  parameter int TEST_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       osc_stop,
  input  logic       ftest,
  input  logic       load,
  input  logic [7:0] set_sec,
  input  logic [7:0] set_min,
  input  logic [7:0] set_hour,
  input  logic [7:0] set_wday,
  input  logic [7:0] set_date,
  input  logic [7:0] set_month,
  input  logic [7:0] set_year,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic          tick;
  logic          test_bit;
  logic [CW-1:0] presc_cnt;
  logic          date_adv;
  logic          year_adv;
  cal_t          cur;
  cal_t          load_val;

  assign load_val = '{year: set_year, month: set_month, date: set_date,
                      wday: set_wday, hour: set_hour, min: set_min,
                      sec: set_sec};

  cal_prescaler #(.TICK_DIV(TICK_DIV), .TEST_DIV(TEST_DIV)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .halt     (osc_stop),
    .clear    (load),
    .tick     (tick),
    .test_bit (test_bit),
    .cnt      (presc_cnt)
  );

  cal_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .cur      (cur),
    .date_adv (date_adv),
    .year_adv (year_adv)
  );

  cal_view u_view (
    .ftest    (ftest),
    .halt     (osc_stop),
    .test_bit (test_bit),
    .cur      (cur),
    .sec_v    (sec_o),
    .min_v    (min_o),
    .hour_v   (hour_o),
    .wday_v   (wday_o),
    .date_v   (date_o),
    .month_v  (month_o),
    .year_v   (year_o)
  );

endmodule

// File: rtl/cal_checker.sv
`timescale 1ns/1ps
module cal_checker
  import cal_pkg::*;
#(
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_stop,
  input logic          ftest,
  input logic          load,
  input cal_t          load_val,
  input logic          tick,
  input logic          date_adv,
  input logic          year_adv,
  input logic [CW-1:0] presc_cnt,
  input cal_t          cur,
  input logic [7:0]    sec_o
);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur)); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur.sec == 8'h59) |=> (cur.sec == 8'h00 && cur.min != $past(cur.min))); // R2

  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    date_adv |=> (cur.hour == 8'h00 && cur.min == 8'h00 && cur.sec == 8'h00)); // R3

  AST_LEAP_FEB: assert property (@(posedge clk) disable iff (!rst_n)
    (date_adv && cur.month == 8'h02 && cur.date == 8'h28 && is_leap(cur.year))
      |=> (cur.date == 8'h29)); // R5

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (date_adv && cur.wday == 8'h07) |=> (cur.wday == 8'h01)); // R6

  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (year_adv && cur.year == 8'h99)
      |=> (cur.year == 8'h00 && cur.month == 8'h01 && cur.date == 8'h01)); // R7

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !load) |=> ($stable(cur) && $stable(presc_cnt))); // R8

  AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val) && presc_cnt == '0)); // R9

  AST_TRUE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (!ftest || osc_stop) |-> (sec_o == cur.sec)); // R10

endmodule

bind bcd_calendar_clock cal_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_stop  (osc_stop),
  .ftest     (ftest),
  .load      (load),
  .load_val  (load_val),
  .tick      (tick),
  .date_adv  (date_adv),
  .year_adv  (year_adv),
  .presc_cnt (presc_cnt),
  .cur       (cur),
  .sec_o     (sec_o)
);

// File: tb/sim_bcd_calendar_clock.sv
`timescale 1ns/1ps
module sim_bcd_calendar_clock;

  localparam int TD = 16;
  localparam int TT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0, osc_stop = 1'b0, ftest = 1'b0, load = 1'b0;
  logic [7:0] set_sec = '0, set_min = '0, set_hour = '0, set_wday = '0;
  logic [7:0] set_date = '0, set_month = '0, set_year = '0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcd_calendar_clock #(.TICK_DIV(TD), .TEST_DIV(TT)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_stop(osc_stop),
    .ftest(ftest), .load(load),
    .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour),
    .set_wday(set_wday), .set_date(set_date), .set_month(set_month),
    .set_year(set_year),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [7:0] y, mo, d, wd, h, mi, s);
    chk(tag, "year", year_o, y);
    chk(tag, "month", month_o, mo);
    chk(tag, "date", date_o, d);
    chk(tag, "wday", wday_o, wd);
    chk(tag, "hour", hour_o, h);
    chk(tag, "min", min_o, mi);
    chk(tag, "sec", sec_o, s);
  endtask

  task automatic put(input logic [7:0] y, mo, d, wd, h, mi, s);
    set_year = y; set_month = mo; set_date = d; set_wday = wd;
    set_hour = h; set_min = mi; set_sec = s;
  endtask

  task automatic do_load(input logic [7:0] y, mo, d, wd, h, mi, s);
    @(negedge clk);
    put(y, mo, d, wd, h, mi, s);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // n clock cycles with osc_en high; returns on the falling edge after the last.
  task automatic pulse(input int n);
    repeat (n) begin
      @(negedge clk);
      osc_en = 1'b1;
    end
    @(negedge clk);
    osc_en = 1'b0;
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_second_step();
    pulse(TD - 1);
    chk("R2 one short", "sec", sec_o, 8'h00);
    pulse(1);
    chk("R2 tick", "sec", sec_o, 8'h01);
    repeat (6) @(negedge clk);
    chk("R2 idle", "sec", sec_o, 8'h01);
    do_load(8'h23, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h09);
    pulse(TD);
    chk("R2 bcd digit", "sec", sec_o, 8'h10);
  endtask

  task automatic t_time_carry();
    do_load(8'h23, 8'h06, 8'h15, 8'h03, 8'h12, 8'h59, 8'h59);
    pulse(TD);
    chk_all("R3 hour carry", 8'h23, 8'h06, 8'h15, 8'h03, 8'h13, 8'h00, 8'h00);
    do_load(8'h23, 8'h06, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59);
    pulse(TD);
    chk_all("R3 R6 day carry", 8'h23, 8'h06, 8'h16, 8'h04, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic roll(input string tag, input logic [7:0] y, mo, d, wd,
                      input logic [7:0] emo, ed, ewd);
    do_load(y, mo, d, wd, 8'h23, 8'h59, 8'h59);
    pulse(TD);
    chk_all(tag, y, emo, ed, ewd, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_month_ends();
    roll("R4 apr30",       8'h23, 8'h04, 8'h30, 8'h05, 8'h05, 8'h01, 8'h06);
    roll("R4 R6 jan31",    8'h23, 8'h01, 8'h31, 8'h07, 8'h02, 8'h01, 8'h01);
    roll("R4 jul30",       8'h23, 8'h07, 8'h30, 8'h02, 8'h07, 8'h31, 8'h03);
    roll("R4 sep30",       8'h23, 8'h09, 8'h30, 8'h01, 8'h10, 8'h01, 8'h02);
    roll("R4 nov30",       8'h23, 8'h11, 8'h30, 8'h04, 8'h12, 8'h01, 8'h05);
    roll("R4 feb28 y23",   8'h23, 8'h02, 8'h28, 8'h01, 8'h03, 8'h01, 8'h02);
    roll("R5 feb28 y24",   8'h24, 8'h02, 8'h28, 8'h03, 8'h02, 8'h29, 8'h04);
    roll("R5 feb29 y24",   8'h24, 8'h02, 8'h29, 8'h04, 8'h03, 8'h01, 8'h05);
    roll("R5 feb28 y00",   8'h00, 8'h02, 8'h28, 8'h06, 8'h02, 8'h29, 8'h07);
    roll("R5 feb28 y12",   8'h12, 8'h02, 8'h28, 8'h02, 8'h02, 8'h29, 8'h03);
    roll("R5 feb28 y10",   8'h10, 8'h02, 8'h28, 8'h07, 8'h03, 8'h01, 8'h01);
    roll("R5 R6 feb28 y96", 8'h96, 8'h02, 8'h28, 8'h07, 8'h02, 8'h29, 8'h01);
  endtask

  task automatic t_new_year();
    do_load(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    pulse(TD);
    chk_all("R7 century", 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
    do_load(8'h41, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    pulse(TD);
    chk_all("R7 year", 8'h42, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_stop();
    do_load(8'h30, 8'h05, 8'h10, 8'h02, 8'h08, 8'h20, 8'h10);
    pulse(10);
    osc_stop = 1'b1;
    pulse(3 * TD);
    chk("R8 frozen", "sec", sec_o, 8'h10);
    osc_stop = 1'b0;
    pulse(TD - 11);
    chk("R8 held count", "sec", sec_o, 8'h10);
    pulse(1);
    chk("R8 resumed", "sec", sec_o, 8'h11);
  endtask

  task automatic t_load();
    do_load(8'h30, 8'h05, 8'h10, 8'h02, 8'h08, 8'h20, 8'h30);
    pulse(10);
    do_load(8'h31, 8'h08, 8'h21, 8'h04, 8'h17, 8'h45, 8'h40);
    chk_all("R9 loaded", 8'h31, 8'h08, 8'h21, 8'h04, 8'h17, 8'h45, 8'h40);
    pulse(TD - 1);
    chk("R9 cleared prescaler", "sec", sec_o, 8'h40);
    pulse(1);
    chk("R9 full second", "sec", sec_o, 8'h41);
    do_load(8'h31, 8'h08, 8'h21, 8'h04, 8'h17, 8'h45, 8'h00);
    pulse(TD - 1);
    @(negedge clk);
    put(8'h32, 8'h09, 8'h22, 8'h05, 8'h18, 8'h46, 8'h45);
    osc_en = 1'b1;
    load = 1'b1;
    @(negedge clk);
    osc_en = 1'b0;
    load = 1'b0;
    chk_all("R9 priority", 8'h32, 8'h09, 8'h22, 8'h05, 8'h18, 8'h46, 8'h45);
    pulse(TD - 1);
    chk("R9 after priority", "sec", sec_o, 8'h45);
    pulse(1);
    chk("R9 priority tick", "sec", sec_o, 8'h46);
  endtask

  task automatic t_ftest();
    do_load(8'h30, 8'h05, 8'h10, 8'h02, 8'h08, 8'h20, 8'h20);
    @(negedge clk);
    ftest = 1'b1;
    #1;
    chk("R10 low phase", "sec", sec_o, 8'h20);
    pulse(TT / 2);
    chk("R10 high phase", "sec", sec_o, 8'h21);
    pulse(TT / 2);
    chk("R10 back low", "sec", sec_o, 8'h20);
    pulse(TT / 2);
    chk("R10 high again", "sec", sec_o, 8'h21);
    osc_stop = 1'b1;
    #1;
    chk("R10 stopped true lsb", "sec", sec_o, 8'h20);
    osc_stop = 1'b0;
    ftest = 1'b0;
    #1;
    chk("R10 off true lsb", "sec", sec_o, 8'h20);
    do_load(8'h30, 8'h05, 8'h10, 8'h02, 8'h08, 8'h20, 8'h21);
    ftest = 1'b1;
    #1;
    chk("R10 replaces lsb", "sec", sec_o, 8'h20);
    chk("R10 other field", "min", min_o, 8'h20);
    ftest = 1'b0;
    #1;
    chk("R10 true odd", "sec", sec_o, 8'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_second_step();
    t_time_carry();
    t_month_ends();
    t_new_year();
    t_stop();
    t_load();
    t_ftest();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule